// File: doc/BRIEF.md
# Dual-Channel 8x8 Transpose Scheduler

This block routes data for a separable 8x8 two-dimensional transform. Samples arrive one per cycle in line-scan order, in blocks of 64 (eight rows of eight). Rows with an even index are collected in a small reorder store that feeds the first one-dimensional channel. Rows with an odd index go to a second store that feeds the second channel. Each channel reads its row back at one word every other cycle. The second channel has one extra register stage, so its words fall in the slots the first channel leaves free. The two streams then share a single write port into a paged transpose buffer.

The one-dimensional transform is not part of this block. Each channel holds a pass-through delay line of fixed latency in its place. The transpose buffer stores each block row by row in its own page. Once a page is complete, it is read out column by column as one contiguous 64-word burst, ready for the second pass. The write page and the read page both step forward once per block.

Top module: `xpose_sched`

## Requirements
- R1: After reset, out_valid and out_first are low, and they stay low while no block has been sent.
- R2: Word j (0..63) of each output burst is the input sample at row j mod 8, column j div 8 of the same block. Input sample i of a block has row i div 8 and column i mod 8.
- R3: out_first is high exactly on word 0 of every output burst, and never without out_valid.
- R4: The 64 words of one output burst appear on 64 consecutive cycles.
- R5: A block whose first sample follows the previous block's last sample on the very next cycle is accepted and output correctly.
- R6: A block that starts 16 or more idle cycles after the previous block is accepted and output correctly.
- R7: Rows 0, 2, 4 and 6 pass through channel 0 and rows 1, 3, 5 and 7 through channel 1. The two channels never present a word to the buffer write port in the same cycle.
- R8: Output bursts keep the order of the input blocks. The four-page buffer never completes a page that is still waiting to be read.
- R9: in_valid is high for all 64 cycles of a block. The block is framed by counting valid samples from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe, held for all 64 samples of a block |
| in_data | input | W | Input sample, line-scan order |
| out_valid | output | 1 | Output word strobe |
| out_first | output | 1 | Marks word 0 of a transposed block |
| out_data | output | W | Transposed output word, column-major |

## Verification
Random sample values are sent in several patterns. The first is a run of back-to-back blocks, which keeps both channels and all four pages busy without a break. The second is a run of blocks separated by exactly 16 idle cycles, the tightest gap that is allowed. The third uses longer random gaps, and the run ends with a mix of back-to-back and gapped blocks. A swapped row or column shows up as a transpose mismatch. A channel-slot collision or a page overrun shows up as a corrupted or missing burst. A reader that stalls between pages shows up as a break inside a burst or a misplaced first marker.

// File: rtl/xpose_sched.sv
module xpose_sched #(
  parameter int W   = 16,
  parameter int LAT = 3,
  parameter int NPG = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic         out_first,
  output logic [W-1:0] out_data
);
  localparam int PGW = $clog2(NPG);
  localparam int AW  = PGW + 6;
  localparam int TW  = 1 + PGW + 6 + W;

  logic [5:0]     icnt;
  logic [PGW-1:0] wpg;
  logic [W-1:0]   rmem [2][8];
  logic [1:0]     st;
  logic [TW-1:0]  ch_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt <= '0;
      wpg  <= '0;
    end else if (in_valid) begin
      icnt <= icnt + 6'd1;
      if (icnt == 6'd63) wpg <= wpg + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (in_valid) rmem[icnt[3]][icnt[2:0]] <= in_data;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic           act;
    logic [3:0]     step;
    logic [2:0]     jrow;
    logic [PGW-1:0] jpg;
    logic [TW-1:0]  rd_q, pre;
    logic [TW-1:0]  dl [LAT];

    assign st[c] = in_valid && icnt[2:0] == 3'd7 && icnt[3] == c[0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act <= 1'b0; step <= '0; jrow <= '0; jpg <= '0;
      end else if (st[c]) begin
        act <= 1'b1; step <= '0; jrow <= icnt[5:3]; jpg <= wpg;
      end else if (act) begin
        step <= step + 4'd1;
        if (step == 4'd15) act <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) rd_q <= '0;
      else if (act && !step[0])
        rd_q <= {1'b1, jpg, jrow, step[3:1], rmem[c][step[3:1]]};
      else rd_q <= '0;
    end

    if (c == 1) begin : g_ext
      logic [TW-1:0] ext;
      always_ff @(posedge clk)
        if (!rst_n) ext <= '0;
        else ext <= rd_q;
      assign pre = ext;
    end else begin : g_noext
      assign pre = rd_q;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < LAT; i++) dl[i] <= '0;
      end else begin
        dl[0] <= pre;
        for (int i = 1; i < LAT; i++) dl[i] <= dl[i-1];
      end
    end
    assign ch_q[c] = dl[LAT-1];

    p_job_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      st[c] |-> (!act || step == 4'd15));
  end

  logic [TW-1:0]  wsel;
  logic           wv, wlast;
  logic [PGW-1:0] wpg_w;
  logic [W-1:0]   tbuf [NPG*64];
  logic [NPG-1:0] full;

  assign wsel  = ch_q[1][TW-1] ? ch_q[1] : ch_q[0];
  assign wv    = wsel[TW-1];
  assign wpg_w = wsel[TW-2 -: PGW];
  assign wlast = wv && wsel[W+5:W] == 6'h3F;

  always_ff @(posedge clk)
    if (wv) tbuf[AW'({wpg_w, wsel[W+5:W]})] <= wsel[W-1:0];

  p_slot_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch_q[0][TW-1] && ch_q[1][TW-1]));

  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wlast |-> !full[wpg_w]);

  logic           ract, go;
  logic [5:0]     rcnt;
  logic [PGW-1:0] rpg, cpg;

  assign go = full[rpg] && (!ract || rcnt == 6'd63);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0;
    end else begin
      if (go) full[rpg] <= 1'b0;
      if (wlast) full[wpg_w] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ract <= 1'b0; rcnt <= '0; rpg <= '0; cpg <= '0;
    end else if (go) begin
      ract <= 1'b1; rcnt <= '0; cpg <= rpg; rpg <= rpg + 1'b1;
    end else if (ract) begin
      rcnt <= rcnt + 6'd1;
      if (rcnt == 6'd63) ract <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= ract;
      out_first <= ract && rcnt == 6'd0;
      if (ract) out_data <= tbuf[AW'({cpg, rcnt[2:0], rcnt[5:3]})];
    end
  end

  p_first_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

  p_burst_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ract && rcnt != 6'd0) |-> $past(ract));
endmodule

// File: tb/tb_xpose_sched.sv
module tb_xpose_sched;
  localparam int W  = 16;
  localparam int NB = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid, out_first;
  logic [W-1:0] out_data;

  int errors = 0;
  int checks = 0;
  int ob = 0;
  int oi = 0;
  bit done = 1'b0;
  logic [W-1:0] blk [NB*64];

  xpose_sched #(.W(W), .LAT(3), .NPG(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_first(out_first), .out_data(out_data));

  always #5 clk = ~clk;

  function automatic int src_idx(int b, int j);
    return b*64 + (j % 8)*8 + (j / 8);
  endfunction

  function automatic int gap_of(int b);
    if (b < 6) return 0;
    if (b < 10) return 16;
    if (b < 14) return 16 + int'($urandom_range(0, 40));
    return ($urandom_range(0, 1) == 0) ? 0 : 16 + int'($urandom_range(0, 8));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (block %0d word %0d)", req, act, exp, ob, oi);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (ob >= NB) chk(1'b0, "R8 extra burst", ob, NB);
        else begin
          // R2 R5 R6 R7: transpose through both channels
          chk(out_data == blk[src_idx(ob, oi)], "R2/R7 data", out_data, blk[src_idx(ob, oi)]);
          chk(out_first == (oi == 0), "R3 first flag", out_first, oi == 0);
          oi++;
          if (oi == 64) begin oi = 0; ob++; end
        end
      end else begin
        if (oi != 0) chk(1'b0, "R4 burst broken", 0, 1);
        if (out_first) chk(1'b0, "R3 first without valid", 1, 0);
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NB*64; i++) blk[i] = W'($urandom);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0 && out_first == 1'b0, "R1 idle after reset", out_valid, 0);
    end
    for (int b = 0; b < NB; b++) begin
      int g;
      g = (b == 0) ? 0 : gap_of(b);
      in_valid = 1'b0;
      repeat (g) @(negedge clk);
      for (int i = 0; i < 64; i++) begin
        in_valid = 1'b1;          // R9 held through the block
        in_data  = blk[b*64 + i];
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    repeat (300) @(negedge clk);
    done = 1'b1;
    chk(ob == NB && oi == 0, "R8 burst count and order", ob, NB);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule